// File: doc/BRIEF.md
# Comparator Event Timer Channel

This block is a single channel of an event timer. A free-running main counter lives outside it and is shared by all channels. Every cycle the channel receives that counter's value and a strobe saying whether the counter stepped. The channel keeps its own comparator and reload period. It emits a one-cycle `fire` pulse when the count reaches the comparator.

The channel has three modes. In one-shot mode it fires once each time it is armed. In periodic mode the comparator moves forward by the period after each hit. A narrowed mode works on the low half of the counter only. In narrowed one-shot mode the channel also fires when the low half of the counter rolls over, provided that rollover comes before the programmed match.

Software programs the channel through three write strobes: one for the configuration word and one for each half of the comparator. The comparator and configuration can be read back continuously. Interrupt routing, status collection and address decoding belong to the surrounding logic.

Top module: `cmp_timer_channel`

## Requirements
- R1: After reset, `cmpValue` is all ones, `cfgValue` reads 0x0030 (bit 4, periodic capable, and bit 5, wide capable), and `fire` is 0. The stored period is 0.
- R2: A configuration write stores only the writable bits 1, 2, 3, 6, 8, 9 to 13 and 14 (mask 0x7F4E). Bits 4 and 5 always read 1. Bit 15 and all other bits read 0. Bit 2 is the channel enable, bit 3 selects periodic mode, bit 6 is the set-value bit and bit 8 selects narrowed (half-width) mode.
- R3: A configuration write with bit 8 set clears the upper half of both the comparator and the period. While bit 8 is set, writes to the upper comparator half are ignored and the upper half of `cmpValue` stays 0.
- R4: A low or high comparator write changes that comparator half only in one-shot mode or when the set-value bit is 1. A low write in periodic mode also loads the low half of the period. A high write in periodic mode with set-value 0 loads only the high half of the period. Any comparator write clears the set-value bit.
- R5: A period half loaded from the top bit of its word has that top bit cleared. In narrowed mode this is bit 31 of a low write; in full mode it is bit 63, via a high write.
- R6: In one-shot mode, or in periodic mode with a zero period, the channel fires once per arming: on the first counter step where (comparator minus count) is zero or negative as a signed value. Arming happens on any comparator write and when enable AND `globalEn` rises. Without a write, the comparator never changes in one-shot mode.
- R7: In periodic mode with a non-zero period, the channel fires on a counter step where the comparator is due, then adds the period. If the comparator is still due, it keeps adding the period, one addition per cycle and without further pulses, until the comparator is ahead of the count.
- R8: In narrowed mode the "due" test uses a 32-bit signed difference of the low halves, and the periodic addition wraps modulo 2^32.
- R9: In narrowed one-shot mode, arming sets a hidden wrap flag when the distance to rollover (all ones minus the low count) is smaller than the distance to the comparator. A distance that is zero or less counts as 1. While the flag is set, the match is held off. The channel fires on the step where the low half of the count reads 0, and that clears the flag. In full mode a low-half rollover never fires.
- R10: `fire` is only raised if both configuration bit 2 and `globalEn` were 1 in the cycle before.
- R11: `fire` is a one-cycle pulse. It is registered, so it follows the clock edge that samples `countTick` high (or, for a periodic catch-up, never).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mainCount | input | 64 | Shared main counter value |
| countTick | input | 1 | Main counter stepped this cycle |
| globalEn | input | 1 | Timer block global enable |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 16 | Configuration write data |
| cmpLoWrEn | input | 1 | Low comparator half write strobe |
| cmpHiWrEn | input | 1 | High comparator half write strobe |
| cmpWrData | input | 32 | Comparator half write data |
| fire | output | 1 | One-cycle event pulse |
| cmpValue | output | 64 | Comparator readback |
| cfgValue | output | 16 | Configuration readback |

## Verification
The hardest case to reach is the narrowed one-shot rollover event. It needs a hidden flag that is set only when arming happens close to the top of the low half of the counter, with a comparator that lies past the rollover. The bench drives `mainCount` directly, so it can park the count a few steps below all ones, arm with a small comparator, and sweep across the rollover. It then expects two pulses: one at low half zero and one at the match. A comparator just short of the rollover is swept the same way and must give a single pulse. The periodic catch-up loop is reached by jumping the count several periods ahead in one step; the bench then waits out the extra additions and reads back the comparator.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int CFG_W = 16;

  localparam int B_LEVEL   = 1;
  localparam int B_EN      = 2;
  localparam int B_PER     = 3;
  localparam int B_PERCAP  = 4;
  localparam int B_WIDECAP = 5;
  localparam int B_SETVAL  = 6;
  localparam int B_NARROW  = 8;
  localparam int B_ROUTE0  = 9;
  localparam int ROUTE_W   = 5;
  localparam int B_MSGEN   = 14;

  localparam logic [CFG_W-1:0] ROUTE_MASK = CFG_W'(((1 << ROUTE_W) - 1) << B_ROUTE0);
  localparam logic [CFG_W-1:0] CFG_WR_MASK =
    CFG_W'((1 << B_LEVEL) | (1 << B_EN) | (1 << B_PER) | (1 << B_SETVAL) |
           (1 << B_NARROW) | (1 << B_MSGEN)) | ROUTE_MASK;
  localparam logic [CFG_W-1:0] CFG_CAPS = CFG_W'((1 << B_PERCAP) | (1 << B_WIDECAP));

  typedef struct packed {
    logic wrCfg;
    logic loadCmpLo;
    logic loadCmpHi;
    logic loadPerLo;
    logic loadPerHi;
    logic clearSetVal;
    logic advance;
  } dpStrobes_t;
endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         stb,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic [HALF_W-1:0]  cmpWrData,
  input  logic [CNT_W-1:0]   mainCount,
  output logic [CFG_W-1:0]   cfgQ,
  output logic [CNT_W-1:0]   cmpQ,
  output logic               perZero,
  output logic               due,
  output logic               dueAfterAdd,
  output logic               wrapCloser,
  output logic               lowZero
);
  logic [CNT_W-1:0] perQ;
  logic [CNT_W-1:0] sumNext;
  logic [CNT_W-1:0] diffNow;
  logic [CNT_W-1:0] diffAfter;
  logic [HALF_W-1:0] wrapDist;
  logic [HALF_W-1:0] matchDist;
  logic narrow;
  logic lowDueNow;

  assign narrow = cfgQ[B_NARROW];

  // Signed "already due" test on a precomputed difference
  function automatic logic dueTest(input logic [CNT_W-1:0] d, input logic nar);
    if (nar) return $signed(d[HALF_W-1:0]) <= 0;
    return $signed(d) <= 0;
  endfunction

  always_comb begin
    if (narrow)
      sumNext = {{HALF_W{1'b0}}, cmpQ[HALF_W-1:0] + perQ[HALF_W-1:0]};
    else
      sumNext = cmpQ + perQ;
    diffNow     = cmpQ - mainCount;
    diffAfter   = sumNext - mainCount;
    due         = dueTest(diffNow, narrow);
    dueAfterAdd = dueTest(diffAfter, narrow);
    lowDueNow   = $signed(diffNow[HALF_W-1:0]) <= 0;
    wrapDist    = ~mainCount[HALF_W-1:0];
    matchDist   = lowDueNow ? HALF_W'(1) : diffNow[HALF_W-1:0];
    wrapCloser  = wrapDist < matchDist;
    lowZero     = mainCount[HALF_W-1:0] == '0;
    perZero     = perQ == '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= CFG_CAPS;
      cmpQ <= '1;
      perQ <= '0;
    end else begin
      if (stb.wrCfg) cfgQ <= (cfgWrData & CFG_WR_MASK) | CFG_CAPS;
      if (stb.clearSetVal) cfgQ[B_SETVAL] <= 1'b0;
      if (stb.wrCfg && cfgWrData[B_NARROW]) begin
        cmpQ[CNT_W-1:HALF_W] <= '0;
        perQ[CNT_W-1:HALF_W] <= '0;
      end
      if (stb.loadCmpLo) cmpQ[HALF_W-1:0] <= cmpWrData;
      if (stb.loadCmpHi) cmpQ[CNT_W-1:HALF_W] <= cmpWrData;
      if (stb.loadPerLo)
        perQ[HALF_W-1:0] <= narrow ? {1'b0, cmpWrData[HALF_W-2:0]} : cmpWrData;
      if (stb.loadPerHi) perQ[CNT_W-1:HALF_W] <= {1'b0, cmpWrData[HALF_W-2:0]};
      if (stb.advance) cmpQ <= sumNext;
    end
  end
endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgQ,
  input  logic             cfgWrEn,
  input  logic             cmpLoWrEn,
  input  logic             cmpHiWrEn,
  input  logic             globalEn,
  input  logic             countTick,
  input  logic             perZero,
  input  logic             due,
  input  logic             dueAfterAdd,
  input  logic             wrapCloser,
  input  logic             lowZero,
  output dpStrobes_t       stb,
  output logic             fire
);
  logic narrow, periodic, setVal, active, activeQ;
  logic cmpWr, hiAllowed, arm, armQ, busy, reload;
  logic pending, wrapFlag, catching;
  logic periodicHit, catchStep, wrapHit, matchHit;

  always_comb begin
    narrow    = cfgQ[B_NARROW];
    periodic  = cfgQ[B_PER];
    setVal    = cfgQ[B_SETVAL];
    active    = cfgQ[B_EN] && globalEn;
    cmpWr     = cmpLoWrEn || cmpHiWrEn;
    hiAllowed = cmpHiWrEn && !narrow;
    arm       = cmpWr || (active && !activeQ);
    busy      = armQ || cmpWr || cfgWrEn;
    reload    = periodic && !perZero;

    periodicHit = !busy && reload && active && countTick && due && !catching;
    catchStep   = !busy && reload && catching && due;
    wrapHit     = !busy && !reload && active && countTick && wrapFlag && lowZero;
    matchHit    = !busy && !reload && active && countTick && pending &&
                  !wrapFlag && due;

    stb.wrCfg       = cfgWrEn;
    stb.loadCmpLo   = cmpLoWrEn && (!periodic || setVal);
    stb.loadPerLo   = cmpLoWrEn && periodic;
    stb.loadCmpHi   = hiAllowed && (!periodic || setVal);
    stb.loadPerHi   = hiAllowed && periodic && !setVal;
    stb.clearSetVal = cmpWr;
    stb.advance     = periodicHit || catchStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      armQ     <= 1'b0;
      pending  <= 1'b0;
      wrapFlag <= 1'b0;
      catching <= 1'b0;
      fire     <= 1'b0;
    end else begin
      activeQ <= active;
      armQ    <= arm;
      fire    <= periodicHit || wrapHit || matchHit;
      if (armQ) begin
        pending  <= 1'b1;
        wrapFlag <= narrow && !periodic && wrapCloser;
      end else begin
        if (wrapHit) wrapFlag <= 1'b0;
        if (matchHit) pending <= 1'b0;
      end
      if (stb.advance) catching <= dueAfterAdd;
      else if (busy || !due || !reload) catching <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  mainCount,
  input  logic              countTick,
  input  logic              globalEn,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              cmpLoWrEn,
  input  logic              cmpHiWrEn,
  input  logic [HALF_W-1:0] cmpWrData,
  output logic              fire,
  output logic [CNT_W-1:0]  cmpValue,
  output logic [CFG_W-1:0]  cfgValue
);
  dpStrobes_t stb;
  logic perZero, due, dueAfterAdd, wrapCloser, lowZero;

  cmp_timer_ctrl u_ctrl (
    .clk, .rstN, .cfgQ(cfgValue), .cfgWrEn, .cmpLoWrEn, .cmpHiWrEn,
    .globalEn, .countTick, .perZero, .due, .dueAfterAdd, .wrapCloser,
    .lowZero, .stb, .fire
  );

  cmp_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk, .rstN, .stb, .cfgWrData, .cmpWrData, .mainCount,
    .cfgQ(cfgValue), .cmpQ(cmpValue), .perZero, .due, .dueAfterAdd,
    .wrapCloser, .lowZero
  );
endmodule

// File: rtl/cmp_timer_checker.sv
module cmp_timer_checker
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             countTick,
  input logic             globalEn,
  input logic             cfgWrEn,
  input logic             cmpLoWrEn,
  input logic             cmpHiWrEn,
  input logic             fire,
  input logic [CNT_W-1:0] cmpValue,
  input logic [CFG_W-1:0] cfgValue
);
  AST_FIRE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> $past(cfgValue[B_EN] && globalEn)); // R10

  AST_FIRE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> $past(countTick)); // R11

  AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cmpLoWrEn || cmpHiWrEn) |=> !cfgValue[B_SETVAL]); // R4

  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cfgValue[B_NARROW] |-> cmpValue[CNT_W-1:HALF_W] == '0); // R3

  AST_ONESHOT_CMP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgValue[B_PER] && !cmpLoWrEn && !cmpHiWrEn && !cfgWrEn) |=> $stable(cmpValue)); // R6
endmodule

bind cmp_timer_channel cmp_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk, .rstN, .countTick, .globalEn, .cfgWrEn, .cmpLoWrEn, .cmpHiWrEn,
  .fire, .cmpValue, .cfgValue
);

// File: tb/cmp_timer_channel_test.sv
module cmp_timer_channel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] mainCount = '0;
  logic        countTick = 1'b0;
  logic        globalEn = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        cmpLoWrEn = 1'b0;
  logic        cmpHiWrEn = 1'b0;
  logic [31:0] cmpWrData = '0;
  logic        fire;
  logic [63:0] cmpValue;
  logic [15:0] cfgValue;

  int checks = 0;
  int failures = 0;
  int fireTotal = 0;
  bit done = 0;

  cmp_timer_channel uut (
    .clk, .rstN, .mainCount, .countTick, .globalEn, .cfgWrEn, .cfgWrData,
    .cmpLoWrEn, .cmpHiWrEn, .cmpWrData, .fire, .cmpValue, .cfgValue
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (fire) fireTotal++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; globalEn = 1'b0; countTick = 1'b0;
    cfgWrEn = 1'b0; cmpLoWrEn = 1'b0; cmpHiWrEn = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic wrCfg(input logic [15:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
    idle(2);
  endtask

  task automatic wrCmp(input bit hi, input logic [31:0] d);
    @(negedge clk); cmpLoWrEn = !hi; cmpHiWrEn = hi; cmpWrData = d;
    @(negedge clk); cmpLoWrEn = 1'b0; cmpHiWrEn = 1'b0;
    idle(2);
  endtask

  // one counter step; returns fire as seen after the sampling edge
  task automatic tickTo(input logic [63:0] v, output logic f);
    @(negedge clk); mainCount = v; countTick = 1'b1;
    @(negedge clk); countTick = 1'b0; f = fire;
  endtask

  task automatic sweep(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] e1, input bit hasE2, input logic [63:0] e2);
    logic f;
    for (logic [63:0] v = a; v <= b; v++) begin
      tickTo(v, f);
      check(req, {63'd0, f}, {63'd0, (v == e1) || (hasE2 && v == e2)});
    end
  endtask

  initial begin
    logic f;
    int base;
    doReset();
    // R1 reset state
    check("R1 cfg", {48'd0, cfgValue}, 64'h30);
    check("R1 cmp", cmpValue, '1);
    check("R1 fire", {63'd0, fire}, 64'd0);

    // R2 writable mask, R3 truncation and ignored high write
    wrCfg(16'hFFFF);
    check("R2 cfg mask", {48'd0, cfgValue}, 64'h7F7E);
    check("R3 truncate", cmpValue, 64'h0000_0000_FFFF_FFFF);
    wrCmp(1'b1, 32'hABCD_0123);
    check("R3 hi ignored", cmpValue, 64'h0000_0000_FFFF_FFFF);
    check("R4 setval cleared", {48'd0, cfgValue}, 64'h7F3E);

    // R6 one-shot full width, exact match once
    doReset();
    globalEn = 1'b1; mainCount = 64'd90;
    wrCfg(16'h0004);
    wrCmp(1'b0, 32'd100);
    wrCmp(1'b1, 32'd0);
    check("R4 one-shot load", cmpValue, 64'd100);
    sweep("R6 one-shot", 64'd91, 64'd115, 64'd100, 0, 0);
    // R6 re-arm with comparator already behind: fires on next step
    wrCmp(1'b0, 32'd50);
    sweep("R6 past-due", 64'd116, 64'd120, 64'd116, 0, 0);

    // R10 gating by global enable, then arming on enable rise
    doReset();
    mainCount = 64'd0;
    wrCfg(16'h0004);
    wrCmp(1'b0, 32'd10);
    wrCmp(1'b1, 32'd0);
    sweep("R10 gated", 64'd1, 64'd20, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    @(negedge clk); globalEn = 1'b1;
    idle(3);
    sweep("R10 enable arms", 64'd21, 64'd23, 64'd21, 0, 0);

    // R7 periodic full width
    doReset();
    globalEn = 1'b1; mainCount = 64'd0;
    wrCfg(16'h004C);
    wrCmp(1'b0, 32'd50);
    check("R4 setval clear periodic", {48'd0, cfgValue}, 64'h3C);
    wrCmp(1'b1, 32'd0);
    check("R4 period hi no cmp", cmpValue, 64'hFFFF_FFFF_0000_0032);
    wrCmp(1'b1, 32'd0);
    // comparator high half was left all ones: load it through set-value
    wrCfg(16'h004C);
    wrCmp(1'b1, 32'd0);
    check("R4 setval hi load", cmpValue, 64'd50);
    base = fireTotal;
    for (logic [63:0] v = 1; v <= 160; v++) begin
      tickTo(v, f);
      check("R7 periodic", {63'd0, f}, {63'd0, v == 50 || v == 100 || v == 150});
    end
    check("R7 cmp after", cmpValue, 64'd200);
    // R7 catch-up: jump far ahead, one pulse, comparator lands ahead
    base = fireTotal;
    tickTo(64'd420, f);
    check("R7 catch-up pulse", {63'd0, f}, 64'd1);
    idle(10);
    check("R7 catch-up cmp", cmpValue, 64'd450);
    check("R7 single pulse", 64'(fireTotal - base), 64'd1);

    // R5 + R8 narrowed periodic: masked period, modulo wrap of the add
    doReset();
    globalEn = 1'b1; mainCount = 64'h8000_0000;
    wrCfg(16'h014C);
    wrCmp(1'b0, 32'h8000_0010);
    check("R8 narrowed load", cmpValue, 64'h8000_0010);
    wrCmp(1'b0, 32'hFFFF_FFFF);
    check("R4 periodic no cmp", cmpValue, 64'h8000_0010);
    tickTo(64'h8000_0010, f);
    check("R8 narrowed fire", {63'd0, f}, 64'd1);
    idle(3);
    check("R5 masked period wrap", cmpValue, 64'h0000_000F);

    // R9 narrowed one-shot with rollover event
    doReset();
    globalEn = 1'b1; mainCount = 64'hFFFF_FFF0;
    wrCfg(16'h0104);
    wrCmp(1'b0, 32'd5);
    sweep("R9 wrap event", 64'hFFFF_FFF1, 64'h1_0000_0008,
          64'h1_0000_0000, 1, 64'h1_0000_0005);
    // R9 comparator before rollover: no wrap event
    doReset();
    globalEn = 1'b1; mainCount = 64'hFFFF_FFF0;
    wrCfg(16'h0104);
    wrCmp(1'b0, 32'hFFFF_FFF8);
    sweep("R9 no wrap", 64'hFFFF_FFF1, 64'h1_0000_0004, 64'hFFFF_FFF8, 0, 0);
    // R9 full mode crossing low rollover: only the match fires
    doReset();
    globalEn = 1'b1; mainCount = 64'hFFFF_FFF0;
    wrCfg(16'h0004);
    wrCmp(1'b0, 32'h10);
    wrCmp(1'b1, 32'h1);
    sweep("R9 full mode", 64'hFFFF_FFF1, 64'h1_0000_0012, 64'h1_0000_0010, 0, 0);

    // R11 pulse lasts one cycle
    doReset();
    globalEn = 1'b1; mainCount = 64'd0;
    wrCfg(16'h0004);
    wrCmp(1'b0, 32'd3);
    wrCmp(1'b1, 32'd0);
    tickTo(64'd3, f);
    check("R11 pulse", {63'd0, f}, 64'd1);
    @(negedge clk);
    check("R11 one cycle", {63'd0, fire}, 64'd0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule